// File: doc/BRIEF.md
# Programmable AND / Fixed OR Logic Array

This block is a small sum-of-products logic array whose AND plane is set by a configuration map and whose OR plane is wired in advance. Four data inputs are each offered to the array in true and inverted form, giving eight literal lines. Sixteen product terms each take any subset of those eight lines. The terms are split into four fixed groups of four, and each group is ORed to one output. Every output is driven in both polarities.

The configuration map holds one bit per crosspoint, where a set bit means the literal is wired into the term. It is shifted in serially on the system clock into a shadow register. A single load strobe then copies it into the active map, so the logic never sees a partly written pattern. The path from the data inputs to the outputs has no register in it.

A typical use is to load a code converter pattern after reset and then use the array as glue logic. One example is the ten-code converter with the output sequence 0, 1, 3, 2, 6, 14, 10, 11, 9, 8 for inputs 0 to 9. Terms that a function does not need are given all eight literals, which forces them to 0.

Top module: `pal_array`

## Requirements
- R1: While `rst` is sampled high, both the shadow and the active map become all ones. After reset, `dout` is 0000 and `dout_n` is 1111 until a new map is loaded.
- R2: Map bit `t*8 + L` wires literal L into product term t. Literal `2*i` is `din[i]` and literal `2*i+1` is the inverse of `din[i]`.
- R3: A product term is the AND of its wired literals. A term with no literals wired is 1. A term that has both polarities of any input wired is 0.
- R4: `dout[k]` is the OR of product terms `4k`, `4k+1`, `4k+2` and `4k+3`, and of no other term.
- R5: `dout_n` is always the bitwise inverse of `dout`.
- R6: On each clock edge where `cfg_en` is high, the shadow register shifts up by one place and takes `cfg_data` into bit 0. After 128 shifts, the first bit sent sits in bit 127. When `cfg_en` is low, the shadow register holds its value.
- R7: Shifting has no effect on the outputs. The active map changes only at a clock edge where `cfg_load` is high, and it then takes the shadow value present before that edge.
- R8: A change on `din` reaches `dout` and `dout_n` without any clock edge.
- R9: The array can be programmed to map input codes 0 to 9, with `din[3]` as the MSB, to outputs 0, 1, 3, 2, 6, 14, 10, 11, 9, 8, where `dout[3]` is the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the shadow map |
| cfg_data | input | 1 | Serial map bit, MSB first |
| cfg_load | input | 1 | Copies the shadow map into the active map |
| din | input | 4 | Logic inputs |
| dout | output | 4 | OR-plane outputs |
| dout_n | output | 4 | Inverted OR-plane outputs |

## Verification
Some properties of the configuration path are checked on every clock edge. The shadow register shifts or holds as `cfg_en` dictates. The active map moves only on a load strobe and then takes the earlier shadow value. Reset erases the map. An erased map holds every output low. The rest needs directed scenarios, because each depends on a particular map:
- the literal ordering inside a term row,
- the fixed grouping of terms into outputs,
- an empty term evaluating to 1,
- the full converter pattern on both output polarities,
- outputs following `din` with no clock edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Literal numbering inside one term row of the configuration map
  function automatic int lit_true_idx(input int var_i);
    return 2 * var_i;
  endfunction

  function automatic int lit_comp_idx(input int var_i);
    return 2 * var_i + 1;
  endfunction
endpackage

// File: rtl/pal_fuse_loader.sv
module pal_fuse_loader #(
  parameter int MAP_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic             cfg_load,
  output logic [MAP_W-1:0] shadow_q,
  output logic [MAP_W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '1;
    end else if (cfg_en) begin
      shadow_q <= {shadow_q[MAP_W-2:0], cfg_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '1;
    end else if (cfg_load) begin
      active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
  import pal_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 16,
  localparam int N_LIT  = 2 * N_IN,
  localparam int MAP_W  = N_TERMS * N_LIT
) (
  input  logic [N_IN-1:0]    din,
  input  logic [MAP_W-1:0]   map,
  output logic [N_TERMS-1:0] terms
);
  logic [N_LIT-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[lit_true_idx(i)] = din[i];
    assign lits[lit_comp_idx(i)] = ~din[i];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_LIT-1:0] row;
    assign row      = map[t*N_LIT +: N_LIT];
    // An unwired literal reads as 1, so an empty row gives 1
    assign terms[t] = &(lits | ~row);
  end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
  parameter int N_TERMS = 16,
  parameter int N_OUT   = 4,
  localparam int TPO    = N_TERMS / N_OUT
) (
  input  logic [N_TERMS-1:0] terms,
  output logic [N_OUT-1:0]   sums
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    assign sums[k] = |terms[k*TPO +: TPO];
  end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 16,
  parameter int N_OUT   = 4,
  localparam int N_LIT  = 2 * N_IN,
  localparam int MAP_W  = N_TERMS * N_LIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  output logic [N_OUT-1:0] dout_n
);
  logic [MAP_W-1:0]   shadow_q;
  logic [MAP_W-1:0]   active_q;
  logic [N_TERMS-1:0] terms;
  logic [N_OUT-1:0]   sums;

  pal_fuse_loader #(.MAP_W(MAP_W)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_data (cfg_data),
    .cfg_load (cfg_load),
    .shadow_q (shadow_q),
    .active_q (active_q)
  );

  pal_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
    .din   (din),
    .map   (active_q),
    .terms (terms)
  );

  pal_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_or (
    .terms (terms),
    .sums  (sums)
  );

  assign dout   = sums;
  assign dout_n = ~sums;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int MAP_W = 128,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_data,
  input logic             cfg_load,
  input logic [MAP_W-1:0] shadow_q,
  input logic [MAP_W-1:0] active_q,
  input logic [N_OUT-1:0] dout
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (shadow_q[MAP_W-1:1] == $past(shadow_q[MAP_W-2:0]) && shadow_q[0] == $past(cfg_data))); // R6
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(shadow_q)); // R6
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(active_q)); // R7
  AST_MAP_COPY: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (active_q == $past(shadow_q))); // R7
  AST_RESET_ERASED: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&active_q && &shadow_q)); // R1
  AST_ERASED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (&active_q) |-> (dout == '0)); // R3
endmodule

bind pal_array pal_array_chk #(.MAP_W(MAP_W), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_data (cfg_data),
  .cfg_load (cfg_load),
  .shadow_q (shadow_q),
  .active_q (active_q),
  .dout     (dout)
);

// File: tb/test_pal_array.sv
module test_pal_array;
  localparam int MAP_W = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_data = 1'b0;
  logic       cfg_load = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] dout;
  logic [3:0] dout_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pal_array i_pal_array (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .cfg_load(cfg_load), .din(din), .dout(dout), .dout_n(dout_n)
  );

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (din=%b)", req, act, exp, din);
    end
  endtask

  // Row for one term: care bit i set means din[i] must equal val[i]
  function automatic logic [7:0] row_of(input logic [3:0] care, input logic [3:0] val);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 4; i++)
      if (care[i]) r[2*i + (val[i] ? 0 : 1)] = 1'b1;
    return r;
  endfunction

  task automatic load_map(input logic [MAP_W-1:0] m);
    for (int b = MAP_W - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_en   = 1'b1;
      cfg_data = m[b];
    end
    @(negedge clk);
    cfg_en   = 1'b0;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  function automatic logic [MAP_W-1:0] conv_map();
    logic [MAP_W-1:0] m = '1;
    m[0*8 +: 8]  = row_of(4'b1111, 4'b0001);
    m[1*8 +: 8]  = row_of(4'b0111, 4'b0010);
    m[2*8 +: 8]  = row_of(4'b0111, 4'b0111);
    m[3*8 +: 8]  = row_of(4'b1001, 4'b1000);
    m[4*8 +: 8]  = row_of(4'b0100, 4'b0100);
    m[5*8 +: 8]  = row_of(4'b0010, 4'b0010);
    m[8*8 +: 8]  = row_of(4'b0110, 4'b0100);
    m[12*8 +: 8] = row_of(4'b1000, 4'b1000);
    m[13*8 +: 8] = row_of(4'b0101, 4'b0101);
    m[14*8 +: 8] = row_of(4'b0110, 4'b0110);
    return m;
  endfunction

  function automatic logic [3:0] conv_exp(input int code);
    case (code)
      0: return 4'd0;   1: return 4'd1;   2: return 4'd3;  3: return 4'd2;
      4: return 4'd6;   5: return 4'd14;  6: return 4'd10; 7: return 4'd11;
      8: return 4'd9;   default: return 4'd8;
    endcase
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int v = 0; v < 16; v++) begin
      din = 4'(v);
      #2;
      check4("R1 erased dout", dout, 4'b0000);
      check4("R1 erased dout_n", dout_n, 4'b1111);
    end
  endtask

  task automatic t_literal_order();
    for (int l = 0; l < 8; l++) begin
      logic [MAP_W-1:0] m = '1;
      m[7:0] = 8'(1 << l);
      load_map(m);
      for (int v = 0; v < 16; v++) begin
        logic [3:0] e;
        din = 4'(v);
        #2;
        e = {3'b000, (l % 2 == 0) ? din[l/2] : ~din[l/2]};
        check4("R2 literal order", dout, e);
      end
    end
  endtask

  task automatic t_grouping();
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) begin
        logic [MAP_W-1:0] m = '1;
        m[(4*k+j)*8 +: 8] = 8'h00;
        load_map(m);
        din = 4'(k * 4 + j);
        #2;
        check4("R4 term group / R3 empty term", dout, 4'(1 << k));
        check4("R5 inverse", dout_n, ~4'(1 << k));
      end
  endtask

  task automatic t_converter();
    load_map(conv_map());
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      din = 4'(c);
      #3;
      check4("R9 converter dout", dout, conv_exp(c));
      check4("R5 converter dout_n", dout_n, ~conv_exp(c));
    end
    // Input change between edges must show without a clock
    @(posedge clk);
    #4;
    din = 4'd5;
    #1;
    check4("R8 no clock needed", dout, 4'd14);
    din = 4'd8;
    #1;
    check4("R8 no clock needed", dout, 4'd9);
  endtask

  task automatic t_shadow();
    din = 4'd5;
    for (int b = 0; b < MAP_W; b++) begin
      @(negedge clk);
      cfg_en   = 1'b1;
      cfg_data = 1'b1;
      if (b % 32 == 31) check4("R7 shift leaves outputs", dout, 4'd14);
    end
    @(negedge clk);
    cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    check4("R7 no load no change", dout, 4'd14);
    cfg_load = 1'b1;
    #2;
    check4("R7 not before edge", dout, 4'd14);
    @(negedge clk);
    cfg_load = 1'b0;
    check4("R7 load erased R6", dout, 4'd0);
  endtask

  task automatic t_msb_first();
    // Only the first bit sent set: lands in bit 127 (term 15, literal 7 = ~din[3])
    logic [MAP_W-1:0] m = '1;
    m[15*8 +: 8] = 8'b1000_0000;
    load_map(m);
    din = 4'b0000;
    #2;
    check4("R6 msb first", dout, 4'b1000);
    din = 4'b1000;
    #2;
    check4("R6 msb first", dout, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_literal_order();
    t_grouping();
    t_msb_first();
    t_converter();
    t_shadow();
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule